// File: doc/BRIEF.md
# Runahead Prefetch Throttle Controller

This block decides, cycle by cycle, whether a runahead prefetcher may send a prefetch toward the shared cache ahead of the vector lanes. The prefetcher's decoder reports each vector-fetch block once it has finished decoding it, together with the total number of load and store bytes in that block. The controller keeps one queue entry per reported block and adds the block's bytes to a running total of decoded but not yet executed traffic. When the lanes report that a block has completed, the oldest entry leaves the queue and its bytes come off the total. The total is therefore corrected once per block, whatever predication or skipped branches did inside that block.

A prefetch request is granted only when four conditions hold: the startup skip is over, the request is unit-stride, the outstanding byte total is below a limit, and fewer cache trackers are held by prefetches than a third of the cache's tracker pool. Requests made during the first few blocks after reset, and requests that are not unit-stride, are dropped at once. A request that is only throttled is held, and the prefetcher keeps it for a later cycle. The controller also keeps its own copy of the vector length and the address registers. Commands from the control processor load these copies. Each prefetch leaves with its address and byte length taken from them.

Top module: `rat_throttle_ctrl`

## Requirements
- R1: After reset the byte queue is empty, the outstanding byte total and the tracker count are zero, the vector length and all address registers read zero, `blk_ready` is high, and the startup skip is active.
- R2: A block report that is accepted (`blk_valid` and `blk_ready` high at a clock edge) appends `blk_bytes` to the queue and adds it to the outstanding byte total.
- R3: `lane_ack` removes the oldest queue entry and subtracts its bytes from the total. An acknowledgement while the queue is empty has no effect.
- R4: An accepted block report and an effective acknowledgement in the same cycle both take effect, and the total changes by the pushed bytes minus the popped bytes.
- R5: While the queue holds `DEPTH` entries, `blk_ready` is low and no report is accepted, so no byte count is lost.
- R6: `pf_grant` is high only while the outstanding byte total is strictly below `LIMIT`.
- R7: Prefetches may hold at most `TRK_TOTAL/3` trackers (at least one). Each grant takes a tracker, each `trk_ack` returns one, and `trk_ack` with no tracker held is ignored.
- R8: Until `SKIP_BLKS` block reports have been accepted since reset, every prefetch request is dropped (`pf_drop` high, `pf_grant` low). Only a reset restarts this count.
- R9: A request with `pf_unit` low (not unit-stride) is dropped and never granted.
- R10: A command with `cmd_op` = 0 loads the vector length from the low `VLEN_W` bits of `cmd_data`. A command with `cmd_op` = 1 loads address register `cmd_idx` with `cmd_data`. Both take effect from the next cycle.
- R11: `pf_addr` equals address register `pf_areg`, and `pf_bytes` equals the vector length shifted left by `pf_esz` (the log2 of the element size in bytes).
- R12: A unit-stride request after the skip that is blocked only by the byte limit or the tracker cap is held: `pf_grant` and `pf_drop` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command from the control processor is present |
| cmd_op | input | 1 | 0 = set vector length, 1 = move to address register |
| cmd_idx | input | $clog2(NAREG) | Address register written by a move |
| cmd_data | input | ADDR_W | Command payload |
| blk_valid | input | 1 | Decoder has finished a vector-fetch block |
| blk_bytes | input | CNT_W | Load and store bytes of that block |
| blk_ready | output | 1 | Queue can take a block report |
| lane_ack | input | 1 | Lanes have completed the oldest block |
| pf_valid | input | 1 | Prefetcher presents a request |
| pf_unit | input | 1 | Request is a unit-stride access |
| pf_areg | input | $clog2(NAREG) | Address register used by the request |
| pf_esz | input | 2 | log2 of the element size in bytes |
| pf_grant | output | 1 | Request is issued this cycle |
| pf_drop | output | 1 | Request is discarded this cycle |
| pf_addr | output | ADDR_W | Prefetch base address |
| pf_bytes | output | VLEN_W+3 | Prefetch length in bytes |
| trk_ack | input | 1 | One prefetch tracker has been released by the cache |

## Verification
Two pairs of events can fall in the same cycle. A block report and a lane acknowledgement can both change the byte total. A prefetch grant and a tracker release can both change the tracker count. The bench provokes both collisions with directed steps and with random traffic whose densities are pushed toward a full queue, an empty queue and a saturated tracker pool. In every cycle it checks grant, drop, ready, address and length against an arithmetic model of queue contents, total and tracker count. A collision that loses either half shows up as a wrong grant decision in a later cycle.

// File: rtl/rat_pkg.sv
package rat_pkg;

    typedef enum logic {
        CMD_SETVL = 1'b0,
        CMD_AMOVE = 1'b1
    } cmd_op_e;

    // Share of cache trackers that prefetches may occupy: one third, never zero.
    function automatic int trk_cap(input int total);
        int cap;
        cap = total / 3;
        if (cap < 1) cap = 1;
        return cap;
    endfunction

endpackage

// File: rtl/rat_bytefifo.sv
module rat_bytefifo #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 12,
    parameter int SUM_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [CNT_W-1:0] push_bytes,
    input  logic             pop_req,
    output logic             full,
    output logic             empty,
    output logic [SUM_W-1:0] sum
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] slot [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [OCC_W-1:0] occ;
    logic             pop;
    logic [CNT_W-1:0] head;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (occ == OCC_W'(DEPTH));
    assign empty = (occ == '0);
    assign pop   = pop_req && !empty;
    assign head  = slot[rd_ptr];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && wr_ptr == PTR_W'(g)) slot[g] <= push_bytes;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            occ    <= '0;
            sum    <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
            sum <= sum + (push ? SUM_W'(push_bytes) : '0) - (pop ? SUM_W'(head) : '0);
        end
    end

    AST_EMPTY_SUM_ZERO: assert property (@(posedge clk) disable iff (rst)
        empty |-> (sum == '0)); // R3
    AST_BOTH_NET: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> (sum == $past(sum) + SUM_W'($past(push_bytes)) - SUM_W'($past(head)))); // R4
endmodule

// File: rtl/rat_cmdregs.sv
module rat_cmdregs #(
    parameter int NAREG  = 32,
    parameter int ADDR_W = 48,
    parameter int VLEN_W = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cmd_valid,
    input  rat_pkg::cmd_op_e          cmd_op,
    input  logic [$clog2(NAREG)-1:0]  cmd_idx,
    input  logic [ADDR_W-1:0]         cmd_data,
    input  logic [$clog2(NAREG)-1:0]  pf_areg,
    input  logic [1:0]                pf_esz,
    output logic [ADDR_W-1:0]         pf_addr,
    output logic [VLEN_W+2:0]         pf_bytes
);
    localparam int AREG_W = $clog2(NAREG);

    logic [ADDR_W-1:0] areg [NAREG];
    logic [VLEN_W-1:0] vlen;

    for (genvar g = 0; g < NAREG; g++) begin : g_areg
        always_ff @(posedge clk) begin
            if (rst)
                areg[g] <= '0;
            else if (cmd_valid && cmd_op == rat_pkg::CMD_AMOVE && cmd_idx == AREG_W'(g))
                areg[g] <= cmd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            vlen <= '0;
        else if (cmd_valid && cmd_op == rat_pkg::CMD_SETVL)
            vlen <= cmd_data[VLEN_W-1:0];
    end

    assign pf_addr  = areg[pf_areg];
    assign pf_bytes = {3'b000, vlen} << pf_esz;

    AST_VL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == rat_pkg::CMD_SETVL) |=> (vlen == $past(cmd_data[VLEN_W-1:0]))); // R10
endmodule

// File: rtl/rat_gate.sv
module rat_gate #(
    parameter int SKIP_BLKS = 2,
    parameter int TRK_TOTAL = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic blk_accept,
    input  logic pf_valid,
    input  logic pf_unit,
    input  logic below_limit,
    input  logic trk_ack,
    output logic pf_grant,
    output logic pf_drop
);
    localparam int CAP  = rat_pkg::trk_cap(TRK_TOTAL);
    localparam int TK_W = $clog2(CAP + 1);
    localparam int SK_W = $clog2(SKIP_BLKS + 2);

    logic [SK_W-1:0] skip_cnt;
    logic [TK_W-1:0] trk_cnt;
    logic            skipping, trk_room, trk_dec;

    assign skipping = (skip_cnt < SK_W'(SKIP_BLKS));
    assign trk_room = (trk_cnt < TK_W'(CAP));
    assign trk_dec  = trk_ack && (trk_cnt != '0);
    assign pf_drop  = pf_valid && (skipping || !pf_unit);
    assign pf_grant = pf_valid && pf_unit && !skipping && below_limit && trk_room;

    always_ff @(posedge clk) begin
        if (rst)
            skip_cnt <= '0;
        else if (blk_accept && skipping)
            skip_cnt <= skip_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_cnt <= '0;
        end else begin
            case ({pf_grant, trk_dec})
                2'b10:   trk_cnt <= trk_cnt + 1'b1;
                2'b01:   trk_cnt <= trk_cnt - 1'b1;
                default: trk_cnt <= trk_cnt;
            endcase
        end
    end

    AST_TRK_CAP: assert property (@(posedge clk) disable iff (rst)
        trk_cnt <= TK_W'(CAP)); // R7
    AST_SKIP_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        skipping |-> !pf_grant); // R8
    AST_GRANT_DROP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(pf_grant && pf_drop)); // R12
endmodule

// File: rtl/rat_throttle_ctrl.sv
module rat_throttle_ctrl #(
    parameter int DEPTH     = 8,
    parameter int CNT_W     = 12,
    parameter int LIMIT     = 4096,
    parameter int TRK_TOTAL = 24,
    parameter int SKIP_BLKS = 2,
    parameter int NAREG     = 32,
    parameter int ADDR_W    = 48,
    parameter int VLEN_W    = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_valid,
    input  logic                     cmd_op,
    input  logic [$clog2(NAREG)-1:0] cmd_idx,
    input  logic [ADDR_W-1:0]        cmd_data,
    input  logic                     blk_valid,
    input  logic [CNT_W-1:0]         blk_bytes,
    output logic                     blk_ready,
    input  logic                     lane_ack,
    input  logic                     pf_valid,
    input  logic                     pf_unit,
    input  logic [$clog2(NAREG)-1:0] pf_areg,
    input  logic [1:0]               pf_esz,
    output logic                     pf_grant,
    output logic                     pf_drop,
    output logic [ADDR_W-1:0]        pf_addr,
    output logic [VLEN_W+2:0]        pf_bytes,
    input  logic                     trk_ack
);
    localparam int SUM_W = CNT_W + $clog2(DEPTH + 1);

    logic             q_full, q_empty, blk_accept, below_limit;
    logic [SUM_W-1:0] out_bytes;

    assign blk_ready   = !q_full;
    assign blk_accept  = blk_valid && !q_full;
    assign below_limit = (out_bytes < SUM_W'(LIMIT));

    rat_bytefifo #(.DEPTH(DEPTH), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (blk_accept),
        .push_bytes (blk_bytes),
        .pop_req    (lane_ack),
        .full       (q_full),
        .empty      (q_empty),
        .sum        (out_bytes)
    );

    rat_gate #(.SKIP_BLKS(SKIP_BLKS), .TRK_TOTAL(TRK_TOTAL)) u_gate (
        .clk         (clk),
        .rst         (rst),
        .blk_accept  (blk_accept),
        .pf_valid    (pf_valid),
        .pf_unit     (pf_unit),
        .below_limit (below_limit),
        .trk_ack     (trk_ack),
        .pf_grant    (pf_grant),
        .pf_drop     (pf_drop)
    );

    rat_cmdregs #(.NAREG(NAREG), .ADDR_W(ADDR_W), .VLEN_W(VLEN_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (rat_pkg::cmd_op_e'(cmd_op)),
        .cmd_idx   (cmd_idx),
        .cmd_data  (cmd_data),
        .pf_areg   (pf_areg),
        .pf_esz    (pf_esz),
        .pf_addr   (pf_addr),
        .pf_bytes  (pf_bytes)
    );

    AST_GRANT_UNDER_LIMIT: assert property (@(posedge clk) disable iff (rst)
        pf_grant |-> (out_bytes < SUM_W'(LIMIT))); // R6
    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !blk_ready |-> !q_empty); // R5
endmodule

// File: tb/sim_rat_throttle_ctrl.sv
module sim_rat_throttle_ctrl;
    localparam int DEPTH = 4, CNT_W = 6, LIMIT = 40, TRK_TOTAL = 9, SKIP_BLKS = 2;
    localparam int NAREG = 4, ADDR_W = 16, VLEN_W = 6;
    localparam int CAP = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_valid = 0, cmd_op = 0;
    logic [1:0] cmd_idx = 0;
    logic [ADDR_W-1:0] cmd_data = 0;
    logic blk_valid = 0;
    logic [CNT_W-1:0] blk_bytes = 0;
    logic blk_ready, lane_ack = 0, pf_valid = 0, pf_unit = 0;
    logic [1:0] pf_areg = 0, pf_esz = 0;
    logic pf_grant, pf_drop, trk_ack = 0;
    logic [ADDR_W-1:0] pf_addr;
    logic [VLEN_W+2:0] pf_bytes;

    always #10 clk = ~clk;

    rat_throttle_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LIMIT(LIMIT), .TRK_TOTAL(TRK_TOTAL),
        .SKIP_BLKS(SKIP_BLKS), .NAREG(NAREG), .ADDR_W(ADDR_W), .VLEN_W(VLEN_W)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .cmd_data(cmd_data), .blk_valid(blk_valid), .blk_bytes(blk_bytes), .blk_ready(blk_ready),
        .lane_ack(lane_ack), .pf_valid(pf_valid), .pf_unit(pf_unit), .pf_areg(pf_areg),
        .pf_esz(pf_esz), .pf_grant(pf_grant), .pf_drop(pf_drop), .pf_addr(pf_addr),
        .pf_bytes(pf_bytes), .trk_ack(trk_ack));

    int checks = 0, errors = 0;
    bit done = 0;
    int q[$];
    int glob, trk, skipc, vlen;
    int areg [NAREG];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        q.delete();
        glob = 0; trk = 0; skipc = 0; vlen = 0;
        for (int i = 0; i < NAREG; i++) areg[i] = 0;
    endtask

    function automatic bit exp_grant();
        return pf_valid && pf_unit && (skipc >= SKIP_BLKS) && (glob < LIMIT) && (trk < CAP);
    endfunction

    function automatic bit exp_drop();
        return pf_valid && ((skipc < SKIP_BLKS) || !pf_unit);
    endfunction

    task automatic check_outputs();
        int eb;
        eb = (vlen << pf_esz);
        chk(blk_ready == (q.size() < DEPTH), "R5 R2", blk_ready, q.size() < DEPTH);
        chk(pf_grant == exp_grant(), "R4 R6 R7 R8 R12", pf_grant, exp_grant());
        chk(pf_drop == exp_drop(), "R8 R9 R12", pf_drop, exp_drop());
        chk(pf_addr == areg[pf_areg], "R10 R11 addr", pf_addr, areg[pf_areg]);
        chk(pf_bytes == eb, "R10 R11 bytes", pf_bytes, eb);
    endtask

    task automatic model_update();
        bit acc, pop, g;
        g   = exp_grant();
        acc = blk_valid && (q.size() < DEPTH);
        pop = lane_ack && (q.size() > 0);
        if (pop) begin glob -= q[0]; void'(q.pop_front()); end
        if (acc) begin q.push_back(int'(blk_bytes)); glob += blk_bytes; end
        if (acc && skipc < SKIP_BLKS) skipc++;
        if (trk_ack && trk > 0) trk--;
        if (g) trk++;
        if (cmd_valid) begin
            if (cmd_op == 1'b0) vlen = int'(cmd_data[VLEN_W-1:0]);
            else areg[cmd_idx] = int'(cmd_data);
        end
    endtask

    task automatic tick();
        #1;
        check_outputs();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle();
        cmd_valid = 0; blk_valid = 0; lane_ack = 0; pf_valid = 0; trk_ack = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1; idle();
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 0; model_reset();
    endtask

    task automatic random_phase(input int n, input int pblk, input int pack, input int ptrk);
        for (int i = 0; i < n; i++) begin
            cmd_valid = ($urandom % 100) < 15;
            cmd_op    = $urandom % 2;
            cmd_idx   = $urandom % NAREG;
            cmd_data  = $urandom;
            blk_valid = ($urandom % 100) < pblk;
            blk_bytes = $urandom_range(0, 31);
            lane_ack  = ($urandom % 100) < pack;
            trk_ack   = ($urandom % 100) < ptrk;
            pf_valid  = ($urandom % 100) < 70;
            pf_unit   = ($urandom % 4) != 0;
            pf_areg   = $urandom % NAREG;
            pf_esz    = $urandom % 4;
            tick();
        end
        idle();
    endtask

    initial begin
        model_reset();
        do_reset();
        // R1: reset state, a unit request is dropped because the skip is active
        pf_valid = 1; pf_unit = 1; pf_areg = 2; pf_esz = 3;
        #1;
        chk(blk_ready == 1, "R1 ready", blk_ready, 1);
        chk(pf_grant == 0 && pf_drop == 1, "R1 R8 skip at reset", {pf_grant, pf_drop}, 1);
        chk(pf_addr == 0 && pf_bytes == 0, "R1 regs zero", pf_addr, 0);
        // R3: acknowledgement on an empty queue is ignored
        lane_ack = 1; tick(); idle();
        // R10: commands, then R11 outputs
        cmd_valid = 1; cmd_op = 0; cmd_data = 16'h0015; tick();
        cmd_op = 1; cmd_idx = 2; cmd_data = 16'hBEEF; tick(); idle();
        pf_valid = 1; pf_unit = 1; pf_areg = 2; pf_esz = 2; #1;
        chk(pf_addr == 16'hBEEF, "R10 R11 addr directed", pf_addr, 16'hBEEF);
        chk(pf_bytes == 84, "R10 R11 length directed", pf_bytes, 84);
        // R8: two blocks end the skip; bytes 30 + 20 = 50 reach the limit
        blk_valid = 1; blk_bytes = 30; tick();
        blk_bytes = 20; tick(); blk_valid = 0;
        #1;
        chk(pf_grant == 0 && pf_drop == 0, "R12 R6 held at limit", {pf_grant, pf_drop}, 0);
        // R4: pop 30 and push 5 in one cycle, total 25
        lane_ack = 1; blk_valid = 1; blk_bytes = 5; tick(); idle();
        pf_valid = 1; pf_unit = 1; #1;
        chk(pf_grant == 1, "R4 net update grants", pf_grant, 1);
        // R9: non-unit-stride dropped
        pf_unit = 0; #1;
        chk(pf_drop == 1 && pf_grant == 0, "R9 strided dropped", {pf_grant, pf_drop}, 1);
        // R7: grant with a tracker release at zero held, then fill the cap
        pf_unit = 1;
        for (int i = 0; i < 5; i++) begin trk_ack = (i == 0); tick(); end
        #1;
        chk(pf_grant == 0, "R7 cap reached", pf_grant, 0);
        trk_ack = 1; tick(); trk_ack = 0; idle();
        random_phase(600, 60, 20, 30);
        random_phase(600, 20, 60, 30);
        random_phase(600, 90, 5, 10);
        do_reset();
        random_phase(600, 40, 40, 50);
        random_phase(600, 70, 70, 5);
        random_phase(600, 50, 50, 80);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule